// File: doc/BRIEF.md
# Pipelined Thermometer-to-Binary Encoder via Gray Code

This block sits behind the comparator bank of a flash converter. Each cycle it takes the full set of comparator decisions as a thermometer word, with tap 1 at the bottom and tap 2^N-1 at the top. It produces the N-bit count of asserted taps as a straight binary code. The conversion runs in two logical steps. Gates first form each Gray bit from alternating thermometer transitions. A chain of XORs then unwinds the Gray code into binary. There is no lookup table anywhere in the path.

Registers split the work so that every stage fits into one comparator clock period. Those registers are the input capture, the Gray bits, the upper half of the XOR chain and the final binary code. A new word can enter on every cycle, and a valid strobe travels alongside the data with the same delay. The default width is N = 5, which means 31 taps and a 5-bit code.

Top module: `therm_gray_encoder`

## Requirements
- R1: A legal thermometer word, meaning taps 1..k set and all taps above k clear for 0 <= k <= 2^N-1, produces `code_out` = k. Bit j of `therm_in` is tap j+1.
- R2: A word with every tap clear produces `code_out` = 0.
- R3: A word with every tap set produces `code_out` = 2^N-1, which is 31 by default.
- R4: A word sampled at rising edge n shows on `code_out` right after rising edge n+3. Words sampled on consecutive edges leave in the same order, one per cycle.
- R5: `out_valid` equals `in_valid` delayed by the same three edges as the data, for any pattern of the strobe.
- R6: While `rst` is high, a rising edge clears `out_valid` and `code_out` to 0. This also applies in the middle of a stream.
- R7: Take a legal word of count c, for 1 <= c <= 2^N-2. Clear tap c and set tap c+1, so the word is still c taps but with one misplaced. This single bubble yields a code within 2 of c and never a larger jump.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Comparator-rate clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a word on `therm_in` as meaningful |
| therm_in | input | 2^N-1 | Comparator decisions; bit j is tap j+1 |
| out_valid | output | 1 | `in_valid` delayed to line up with `code_out` |
| code_out | output | N | Binary code, registered |

## Verification
The data-path assertions take for granted that the comparator word is legal, that is, a contiguous run of ones starting at tap 1. They also assume that four clean cycles have passed since reset. Bubbled words are outside what they check, and those words are judged only by the bench against the bound of R7. The stimulus applies a legal word in every sweep, idle and reset phase. Bubbles are confined to the single misplaced-tap form of R7 at each possible position.

// File: rtl/tge_pkg.sv
package tge_pkg;
  // Number of comparator taps for a given output width.
  function automatic int unsigned tap_count(input int unsigned bits);
    return (1 << bits) - 1;
  endfunction

  // Pipeline ranks from the input capture to the output register.
  localparam int unsigned PIPE_EDGES = 3;
endpackage

// File: rtl/tge_in_reg.sv
module tge_in_reg #(
  parameter int unsigned NT = 31
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld_i,
  input  logic [NT-1:0] th_i,
  output logic          vld_o,
  output logic [NT-1:0] th_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      th_o  <= '0;
    end else begin
      vld_o <= vld_i;
      th_o  <= th_i;
    end
  end
endmodule

// File: rtl/tge_gray_stage.sv
module tge_gray_stage #(
  parameter int unsigned N = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         vld_i,
  input  logic [tge_pkg::tap_count(N)-1:0] th_i,
  output logic                         vld_o,
  output logic [N-1:0]                 gray_o
);
  localparam int unsigned NT = tge_pkg::tap_count(N);

  logic [N-1:0] gray_c;

  // Gray bit k collects taps at odd multiples of 2^k. Each positive term
  // is a tap at (4j+1)*2^k that is set while the tap 2^(k+1) above it is clear.
  for (genvar k = 0; k < N; k++) begin : g_bit
    localparam int unsigned STEP = 1 << k;
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int p = 1; p <= NT; p++) begin
        if ((p % (4 * STEP)) == STEP) begin
          if (p + 2 * STEP <= NT)
            acc = acc | (th_i[p-1] & ~th_i[(p + 2 * STEP - 1) % NT]);
          else
            acc = acc | th_i[p-1];
        end
      end
    end
    assign gray_c[k] = acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      gray_o <= '0;
    end else begin
      vld_o  <= vld_i;
      gray_o <= gray_c;
    end
  end
endmodule

// File: rtl/tge_xor_hi.sv
module tge_xor_hi #(
  parameter int unsigned N  = 5,
  parameter int unsigned LO = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld_i,
  input  logic [N-1:0]  gray_i,
  output logic          vld_o,
  output logic [N-1:LO] bin_hi_o,
  output logic [LO-1:0] gray_lo_o
);
  logic [N-1:LO] bin_c;

  // Upper part of the ripple: b[N-1] = g[N-1], b[i] = b[i+1] ^ g[i].
  always_comb begin
    bin_c[N-1] = gray_i[N-1];
    for (int i = N - 2; i >= int'(LO); i--)
      bin_c[i] = bin_c[i+1] ^ gray_i[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o     <= 1'b0;
      bin_hi_o  <= '0;
      gray_lo_o <= '0;
    end else begin
      vld_o     <= vld_i;
      bin_hi_o  <= bin_c;
      gray_lo_o <= gray_i[LO-1:0];
    end
  end
endmodule

// File: rtl/tge_xor_lo.sv
module tge_xor_lo #(
  parameter int unsigned N  = 5,
  parameter int unsigned LO = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld_i,
  input  logic [N-1:LO] bin_hi_i,
  input  logic [LO-1:0] gray_lo_i,
  output logic          vld_o,
  output logic [N-1:0]  bin_o
);
  logic [N-1:0] bin_c;

  // Finish the ripple below the split point.
  always_comb begin
    bin_c[N-1:LO] = bin_hi_i;
    for (int i = int'(LO) - 1; i >= 0; i--)
      bin_c[i] = bin_c[i+1] ^ gray_lo_i[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      bin_o <= '0;
    end else begin
      vld_o <= vld_i;
      bin_o <= bin_c;
    end
  end
endmodule

// File: rtl/therm_gray_encoder.sv
module therm_gray_encoder #(
  parameter int unsigned N = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  input  logic [tge_pkg::tap_count(N)-1:0]  therm_in,
  output logic                              out_valid,
  output logic [N-1:0]                      code_out
);
  localparam int unsigned NT = tge_pkg::tap_count(N);
  localparam int unsigned LO = (N / 2 < 1) ? 1 : N / 2;

  logic          s0_vld;
  logic [NT-1:0] s0_th;
  logic          s1_vld;
  logic [N-1:0]  s1_gray;
  logic          s2_vld;
  logic [N-1:LO] s2_bin_hi;
  logic [LO-1:0] s2_gray_lo;

  tge_in_reg #(.NT(NT)) u_in (
    .clk(clk), .rst(rst), .vld_i(in_valid), .th_i(therm_in),
    .vld_o(s0_vld), .th_o(s0_th)
  );

  tge_gray_stage #(.N(N)) u_gray (
    .clk(clk), .rst(rst), .vld_i(s0_vld), .th_i(s0_th),
    .vld_o(s1_vld), .gray_o(s1_gray)
  );

  tge_xor_hi #(.N(N), .LO(LO)) u_hi (
    .clk(clk), .rst(rst), .vld_i(s1_vld), .gray_i(s1_gray),
    .vld_o(s2_vld), .bin_hi_o(s2_bin_hi), .gray_lo_o(s2_gray_lo)
  );

  tge_xor_lo #(.N(N), .LO(LO)) u_lo (
    .clk(clk), .rst(rst), .vld_i(s2_vld), .bin_hi_i(s2_bin_hi),
    .gray_lo_i(s2_gray_lo), .vld_o(out_valid), .bin_o(code_out)
  );
endmodule

// File: rtl/tge_encoder_chk.sv
module tge_encoder_chk #(
  parameter int unsigned N = 5
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             in_valid,
  input logic [tge_pkg::tap_count(N)-1:0] therm_in,
  input logic                             out_valid,
  input logic [N-1:0]                     code_out
);
  localparam int unsigned NT = tge_pkg::tap_count(N);

  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  logic warm;
  assign warm = (since_rst == 3'd4);

  logic legal_in;
  assign legal_in = ((therm_in & (therm_in + 1'b1)) == '0);

  assert_reset_clears_R6: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && code_out == '0));

  assert_valid_delay_R5: assert property (@(posedge clk) disable iff (rst)
    warm |-> (out_valid == $past(in_valid, 4)));

  assert_count_match_R1: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(legal_in, 4)) |->
      (int'(code_out) == $past($countones(therm_in), 4)));

  assert_full_scale_R3: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(&therm_in, 4)) |-> (&code_out));

  assert_zero_scale_R2: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(therm_in == '0, 4)) |-> (code_out == '0));

  // R4: three edges after capture, so an idle-to-valid step shows one edge later.
  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(in_valid, 4) && !$past(in_valid, 5 - 1 + 1)) |-> $rose(out_valid));

  initial assert (NT >= 3) else $error("tap count too small");
endmodule

bind therm_gray_encoder tge_encoder_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .therm_in(therm_in),
  .out_valid(out_valid), .code_out(code_out)
);

// File: tb/sim_therm_gray_encoder.sv
`timescale 1ns/1ps
module sim_therm_gray_encoder;
  localparam int N  = 5;
  localparam int NT = (1 << N) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [NT-1:0] therm_in = '0;
  logic          out_valid;
  logic [N-1:0]  code_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [NT-1:0] s_th  [64];
  logic          s_v   [64];
  int            s_exp [64];
  int            s_tol [64];
  int            s_n;

  always #2.5 clk = ~clk;

  therm_gray_encoder #(.N(N)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .therm_in(therm_in),
    .out_valid(out_valid), .code_out(code_out)
  );

  function automatic logic [NT-1:0] therm_of(int k);
    logic [NT-1:0] w = '0;
    for (int i = 0; i < k; i++) w[i] = 1'b1;
    return w;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Plays the stored stream; the item driven at negedge i is checked at negedge i+4.
  task automatic play(string req);
    for (int i = 0; i < s_n + 4; i++) begin
      @(negedge clk);
      if (i >= 4) begin
        int j = i - 4;
        chk(out_valid == s_v[j], {req, " valid"}, int'(out_valid), int'(s_v[j]));
        if (s_v[j]) begin
          int d = int'(code_out) - s_exp[j];
          if (d < 0) d = -d;
          chk(d <= s_tol[j], req, int'(code_out), s_exp[j]);
        end
      end
      if (i < s_n) begin
        therm_in = s_th[i];
        in_valid = s_v[i];
      end else begin
        therm_in = '0;
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R6", int'(out_valid), 0);
    chk(code_out == '0, "R6", int'(code_out), 0);
    rst = 1'b0;
  endtask

  task automatic t_sweep_up;
    s_n = NT + 1;
    for (int k = 0; k <= NT; k++) begin
      s_th[k] = therm_of(k); s_v[k] = 1'b1; s_exp[k] = k; s_tol[k] = 0;
    end
    play("R1");
  endtask

  task automatic t_sweep_down;
    s_n = NT + 1;
    for (int k = 0; k <= NT; k++) begin
      s_th[k] = therm_of(NT - k); s_v[k] = 1'b1; s_exp[k] = NT - k; s_tol[k] = 0;
    end
    play("R4");
  endtask

  task automatic t_ends;
    s_n = 6;
    for (int k = 0; k < 6; k++) begin
      s_th[k] = (k % 2 == 0) ? '1 : '0; s_v[k] = 1'b1;
      s_exp[k] = (k % 2 == 0) ? NT : 0; s_tol[k] = 0;
    end
    play("R2 R3");
  endtask

  task automatic t_latency;
    @(negedge clk);
    therm_in = therm_of(7); in_valid = 1'b1;
    @(negedge clk);
    therm_in = '0; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R4 early", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R4", int'(out_valid), 1);
    chk(code_out == 5'd7, "R4", int'(code_out), 7);
    @(negedge clk);
    chk(out_valid == 1'b0, "R4 tail", int'(out_valid), 0);
  endtask

  task automatic t_valid_mix;
    s_n = 12;
    for (int k = 0; k < 12; k++) begin
      s_th[k] = therm_of((k * 5) % (NT + 1));
      s_v[k] = ((k % 3) != 1);
      s_exp[k] = (k * 5) % (NT + 1); s_tol[k] = 0;
    end
    play("R5");
  endtask

  task automatic t_bubble;
    s_n = NT - 1;
    for (int c = 1; c <= NT - 1; c++) begin
      logic [NT-1:0] w = therm_of(c);
      w[c-1] = 1'b0;
      w[c]   = 1'b1;
      s_th[c-1] = w; s_v[c-1] = 1'b1; s_exp[c-1] = c; s_tol[c-1] = 2;
    end
    play("R7");
  endtask

  task automatic t_midreset;
    @(negedge clk);
    therm_in = therm_of(19); in_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk(code_out == 5'd19 && out_valid, "R6 pre", int'(code_out), 19);
    rst = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R6", int'(out_valid), 0);
    chk(code_out == '0, "R6", int'(code_out), 0);
    rst = 1'b0; in_valid = 1'b0; therm_in = '0;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R6 after", int'(out_valid), 0);
  endtask

  initial begin
    t_reset();
    t_sweep_up();
    t_sweep_down();
    t_ends();
    t_latency();
    t_valid_mix();
    t_bubble();
    t_midreset();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule